// File: doc/BRIEF.md
# Two-Channel Bus Break Comparator

This block watches every cycle on a processor bus and raises a break interrupt request when a cycle meets the conditions programmed on one of two channels. Channel A compares the bus address with a programmed value. Bits set in its mask are left out of that comparison. Channel B does the same for the address. It also compares the bus data with a programmed value under a second mask.

Each channel accepts a cycle only if the cycle passes three qualifier groups: who drives the cycle (CPU or peripheral), what kind of access it is (instruction fetch or data), and its direction (read or write). A match sets a sticky flag for that channel. Each channel has one flag for CPU-side matches and one for peripheral-side matches. For a channel B instruction-fetch match, software can hold the request until the fetched instruction has completed.

The request is held pending until it is acknowledged. It is marked as taken whenever the current interrupt mask level would admit a level-15 request. Software programs and inspects the block through a small word-indexed register port.

Top module: `bus_break_unit`

## Requirements
- R1: After a synchronous active-low reset, every register reads 0, all match flags are clear, post-execution mode is off and `brk_req` is low. Register indices: 0 A address, 1 A mask, 2 A qualifier, 3 B address, 4 B mask, 5 B qualifier, 6 B data, 7 B data mask, 8 control.
- R2: Channel A matches when the bus address equals the A address register in every bit whose A mask bit is 0. Bits whose mask bit is 1 are ignored.
- R3: Channel B matches only when the address matches under the B mask and the data matches under the B data mask (mask bit 1 = ignore).
- R4: A qualifier register holds three 2-bit groups: bits[1:0] source (bit0 CPU, bit1 peripheral), bits[3:2] access (bit2 fetch, bit3 data), bits[5:4] direction (bit4 read, bit5 write). A cycle passes a group when the bit for its attribute is set. A group of 00 means the channel never matches.
- R5: A match sets a control-register flag in the next cycle: bit0 A-CPU, bit1 A-peripheral, bit2 B-CPU, bit3 B-peripheral.
- R6: Flags are never cleared by hardware or by acknowledge. Writing 0 to a flag bit clears it. Writing 1 leaves it unchanged. A match in the same cycle as a clearing write wins.
- R7: Control bits[31:5] always read 0. Control bit4 selects post-execution mode for channel B fetch breaks and reads back as written.
- R8: A data-access match, any channel A match, or a channel B fetch match with bit4=0 raises `brk_req` in the next cycle. With bit4=1, a channel B fetch match raises `brk_req` only in the cycle after a later `insn_done` pulse.
- R9: `brk_req` stays high until `brk_ack` is seen and then drops in the next cycle. A new break event in the acknowledge cycle keeps it high.
- R10: `brk_take` is high only while `brk_req` is high and `int_mask` is 14 or lower. At mask 15 the request stays pending and is not taken.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_valid | input | 1 | A bus cycle is present this clock |
| bus_addr | input | AW | Bus cycle address |
| bus_data | input | DW | Bus cycle data |
| bus_periph | input | 1 | 1 = peripheral-side cycle, 0 = CPU-side |
| bus_isdata | input | 1 | 1 = data access, 0 = instruction fetch |
| bus_write | input | 1 | 1 = write, 0 = read |
| insn_done | input | 1 | One-cycle strobe when an instruction completes |
| reg_we | input | 1 | Register write enable |
| reg_addr | input | 4 | Register word index |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| int_mask | input | 4 | Current interrupt mask level |
| brk_ack | input | 1 | Acknowledge of the pending break request |
| brk_req | output | 1 | Pending break request, level 15 |
| brk_take | output | 1 | Request is accepted at the current mask level |

## Verification
The assertions assume that every bus attribute is valid while `bus_valid` is high, and that `insn_done` and `brk_ack` are single-cycle pulses. They also assume that a register write does not change the qualifiers in the same cycle as the bus cycle they should judge. The stimulus meets these assumptions. It changes inputs only on the falling clock edge, holds each bus cycle for exactly one clock, and issues register writes and acknowledges only on clocks where `bus_valid` is low. Fetch cycles in post-execution mode are always followed by a separate `insn_done` pulse a few clocks later. This matches the order of fetch followed by completion.

// File: rtl/brk_pkg.sv
// Package: shared types and register indices for the bus break comparator.
// Assumes a 32-bit register port; indices are word numbers.
package brk_pkg;
    // Qualifier groups, low bit = first option, high bit = second option
    typedef struct packed {
        logic [1:0] dir;   // bit0 read, bit1 write
        logic [1:0] acc;   // bit0 fetch, bit1 data
        logic [1:0] src;   // bit0 CPU, bit1 peripheral
    } qual_t;

    localparam int unsigned REG_W   = 32;
    localparam int unsigned NCH     = 2;
    localparam int unsigned NFLAG   = 2 * NCH;

    localparam logic [3:0] REG_A_ADDR  = 4'd0;
    localparam logic [3:0] REG_A_MASK  = 4'd1;
    localparam logic [3:0] REG_A_QUAL  = 4'd2;
    localparam logic [3:0] REG_B_ADDR  = 4'd3;
    localparam logic [3:0] REG_B_MASK  = 4'd4;
    localparam logic [3:0] REG_B_QUAL  = 4'd5;
    localparam logic [3:0] REG_B_DATA  = 4'd6;
    localparam logic [3:0] REG_B_DMASK = 4'd7;
    localparam logic [3:0] REG_CTRL    = 4'd8;

    localparam int unsigned POST_BIT = 4;
endpackage

// File: rtl/brk_channel.sv
// Module: one break channel comparator.
// Does: compares a bus cycle against a masked address (and, when HAS_DATA,
// a masked data value) and its three qualifier groups; purely combinational.
// Assumes: mask bit 1 excludes that bit; a 00 qualifier group never passes.
module brk_channel
    import brk_pkg::*;
#(
    parameter int unsigned AW       = 32,
    parameter int unsigned DW       = 32,
    parameter bit          HAS_DATA = 1'b0
) (
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_periph,
    input  logic          bus_isdata,
    input  logic          bus_write,
    input  logic [AW-1:0] cfg_addr,
    input  logic [AW-1:0] cfg_amask,
    input  logic [DW-1:0] cfg_data,
    input  logic [DW-1:0] cfg_dmask,
    input  qual_t         cfg_qual,
    output logic          hit
);
    logic addr_ok, data_ok, src_ok, acc_ok, dir_ok;

    // Address compare, masked bits excluded
    assign addr_ok = (((bus_addr ^ cfg_addr) & ~cfg_amask) == '0);

    generate
        if (HAS_DATA) begin : g_data
            // Data compare, masked bits excluded
            assign data_ok = (((bus_data ^ cfg_data) & ~cfg_dmask) == '0);
        end else begin : g_nodata
            logic unused_data;
            assign unused_data = ^{bus_data, cfg_data, cfg_dmask};
            assign data_ok     = 1'b1;
        end
    endgenerate

    // Each qualifier group passes when the bit for the cycle's attribute is set
    assign src_ok = bus_periph ? cfg_qual.src[1] : cfg_qual.src[0];
    assign acc_ok = bus_isdata ? cfg_qual.acc[1] : cfg_qual.acc[0];
    assign dir_ok = bus_write  ? cfg_qual.dir[1] : cfg_qual.dir[0];

    assign hit = bus_valid && addr_ok && data_ok && src_ok && acc_ok && dir_ok;
endmodule

// File: rtl/brk_regs.sv
// Module: configuration registers and sticky match flags.
// Does: holds both channels' compare values, masks and qualifiers, the
// post-execution select and four sticky flags; read data is combinational.
// Assumes: AW and DW are at most 32; a flag set wins over a clearing write.
module brk_regs
    import brk_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [3:0]        addr,
    input  logic [REG_W-1:0]  wdata,
    output logic [REG_W-1:0]  rdata,
    input  logic [NFLAG-1:0]  set_flags,
    output logic [AW-1:0]     a_addr,
    output logic [AW-1:0]     a_amask,
    output qual_t             a_qual,
    output logic [AW-1:0]     b_addr,
    output logic [AW-1:0]     b_amask,
    output qual_t             b_qual,
    output logic [DW-1:0]     b_data,
    output logic [DW-1:0]     b_dmask,
    output logic              post_mode,
    output logic [NFLAG-1:0]  flags
);
    logic [NFLAG-1:0] keep;
    logic             ctrl_wr;

    assign ctrl_wr = we && (addr == REG_CTRL);
    // Flag bits written with 0 are dropped, all others kept
    assign keep = ctrl_wr ? wdata[NFLAG-1:0] : '1;

    // Register writes and flag update
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            a_addr <= '0; a_amask <= '0; a_qual <= '0;
            b_addr <= '0; b_amask <= '0; b_qual <= '0;
            b_data <= '0; b_dmask <= '0;
            post_mode <= 1'b0;
            flags     <= '0;
        end else begin
            flags <= (flags & keep) | set_flags;
            if (we) begin
                case (addr)
                    REG_A_ADDR:  a_addr    <= wdata[AW-1:0];
                    REG_A_MASK:  a_amask   <= wdata[AW-1:0];
                    REG_A_QUAL:  a_qual    <= qual_t'(wdata[5:0]);
                    REG_B_ADDR:  b_addr    <= wdata[AW-1:0];
                    REG_B_MASK:  b_amask   <= wdata[AW-1:0];
                    REG_B_QUAL:  b_qual    <= qual_t'(wdata[5:0]);
                    REG_B_DATA:  b_data    <= wdata[DW-1:0];
                    REG_B_DMASK: b_dmask   <= wdata[DW-1:0];
                    REG_CTRL:    post_mode <= wdata[POST_BIT];
                    default: ;
                endcase
            end
        end
    end

    // Read mux, unused bits read 0
    always_comb begin
        rdata = '0;
        case (addr)
            REG_A_ADDR:  rdata = REG_W'(a_addr);
            REG_A_MASK:  rdata = REG_W'(a_amask);
            REG_A_QUAL:  rdata = REG_W'(a_qual);
            REG_B_ADDR:  rdata = REG_W'(b_addr);
            REG_B_MASK:  rdata = REG_W'(b_amask);
            REG_B_QUAL:  rdata = REG_W'(b_qual);
            REG_B_DATA:  rdata = REG_W'(b_data);
            REG_B_DMASK: rdata = REG_W'(b_dmask);
            REG_CTRL:    rdata = REG_W'({post_mode, flags});
            default:     rdata = '0;
        endcase
    end

    // R6
    flag_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((flags & $past(flags & keep)) == $past(flags & keep)));

    // R7
    reserved_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (addr == REG_CTRL) |-> (rdata[REG_W-1:POST_BIT+1] == '0));
endmodule

// File: rtl/brk_request.sv
// Module: break request pending and acceptance logic.
// Does: turns channel hits into a level-15 request, holding channel B fetch
// hits until an instruction completes in post-execution mode; clears on ack.
// Assumes: insn_done and brk_ack are single-cycle pulses.
module brk_request (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       hit_a,
    input  logic       hit_b,
    input  logic       b_fetch,
    input  logic       post_mode,
    input  logic       insn_done,
    input  logic       brk_ack,
    input  logic [3:0] int_mask,
    output logic       brk_req,
    output logic       brk_take
);
    localparam logic [3:0] MAX_LVL = 4'hF;

    logic armed, pending, defer, set_evt;

    assign defer   = hit_b && b_fetch && post_mode;
    assign set_evt = hit_a || (hit_b && !defer) || (armed && insn_done);

    // Remember a deferred fetch break until the instruction completes
    always_ff @(posedge clk) begin
        if (!rst_n)         armed <= 1'b0;
        else if (defer)     armed <= 1'b1;
        else if (insn_done) armed <= 1'b0;
    end

    // Pending request: new event wins, otherwise ack clears
    always_ff @(posedge clk) begin
        if (!rst_n)        pending <= 1'b0;
        else if (set_evt)  pending <= 1'b1;
        else if (brk_ack)  pending <= 1'b0;
    end

    assign brk_req  = pending;
    assign brk_take = pending && (int_mask != MAX_LVL);

    // R9
    pend_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pending && !brk_ack) |=> pending);

    // R9
    ack_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (brk_ack && !hit_a && !hit_b && !(armed && insn_done)) |=> !pending);

    // R8
    post_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (post_mode && hit_b && b_fetch && !hit_a && !pending && !armed) |=> !pending);
endmodule

// File: rtl/bus_break_unit.sv
// Module: top of the two-channel bus break comparator.
// Does: ties the register block, two channel comparators and the request
// logic together and steers hits into CPU/peripheral sticky flags.
// Assumes: bus attributes are valid whenever bus_valid is high.
module bus_break_unit
    import brk_pkg::*;
#(
    parameter int unsigned AW = 32,
    parameter int unsigned DW = 32
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          bus_valid,
    input  logic [AW-1:0] bus_addr,
    input  logic [DW-1:0] bus_data,
    input  logic          bus_periph,
    input  logic          bus_isdata,
    input  logic          bus_write,
    input  logic          insn_done,
    input  logic          reg_we,
    input  logic [3:0]    reg_addr,
    input  logic [31:0]   reg_wdata,
    output logic [31:0]   reg_rdata,
    input  logic [3:0]    int_mask,
    input  logic          brk_ack,
    output logic          brk_req,
    output logic          brk_take
);
    logic [AW-1:0]    ch_addr  [NCH];
    logic [AW-1:0]    ch_amask [NCH];
    qual_t            ch_qual  [NCH];
    logic [DW-1:0]    b_data, b_dmask;
    logic [NCH-1:0]   hit;
    logic [NFLAG-1:0] flags, set_flags;
    logic             post_mode;

    brk_regs #(.AW(AW), .DW(DW)) u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr),
        .wdata(reg_wdata), .rdata(reg_rdata), .set_flags(set_flags),
        .a_addr(ch_addr[0]), .a_amask(ch_amask[0]), .a_qual(ch_qual[0]),
        .b_addr(ch_addr[1]), .b_amask(ch_amask[1]), .b_qual(ch_qual[1]),
        .b_data(b_data), .b_dmask(b_dmask),
        .post_mode(post_mode), .flags(flags)
    );

    genvar ch;
    generate
        for (ch = 0; ch < NCH; ch++) begin : g_ch
            brk_channel #(.AW(AW), .DW(DW), .HAS_DATA(ch == 1)) u_ch (
                .bus_valid(bus_valid), .bus_addr(bus_addr), .bus_data(bus_data),
                .bus_periph(bus_periph), .bus_isdata(bus_isdata),
                .bus_write(bus_write),
                .cfg_addr(ch_addr[ch]), .cfg_amask(ch_amask[ch]),
                .cfg_data(b_data), .cfg_dmask(b_dmask),
                .cfg_qual(ch_qual[ch]), .hit(hit[ch])
            );
            // Flag pair per channel: low bit CPU side, high bit peripheral side
            assign set_flags[2*ch]   = hit[ch] && !bus_periph;
            assign set_flags[2*ch+1] = hit[ch] &&  bus_periph;
        end
    endgenerate

    brk_request u_req (
        .clk(clk), .rst_n(rst_n), .hit_a(hit[0]), .hit_b(hit[1]),
        .b_fetch(!bus_isdata), .post_mode(post_mode), .insn_done(insn_done),
        .brk_ack(brk_ack), .int_mask(int_mask),
        .brk_req(brk_req), .brk_take(brk_take)
    );

    // R5
    flag_set_a_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[0] && !bus_periph) |=> flags[0]);

    // R5
    flag_set_b_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (hit[1] && bus_periph) |=> flags[3]);

    // R10
    mask_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (int_mask == 4'hF) |-> !brk_take);
endmodule

// File: tb/sim_bus_break_unit.sv
`timescale 1ns/1ps
module sim_bus_break_unit;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_valid = 1'b0;
    logic [31:0] bus_addr = '0;
    logic [31:0] bus_data = '0;
    logic        bus_periph = 1'b0, bus_isdata = 1'b0, bus_write = 1'b0;
    logic        insn_done = 1'b0;
    logic        reg_we = 1'b0;
    logic [3:0]  reg_addr = 4'd8;
    logic [31:0] reg_wdata = '0;
    logic [31:0] reg_rdata;
    logic [3:0]  int_mask = 4'd0;
    logic        brk_ack = 1'b0;
    logic        brk_req, brk_take;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bus_break_unit u0 (
        .clk(clk), .rst_n(rst_n), .bus_valid(bus_valid), .bus_addr(bus_addr),
        .bus_data(bus_data), .bus_periph(bus_periph), .bus_isdata(bus_isdata),
        .bus_write(bus_write), .insn_done(insn_done), .reg_we(reg_we),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .int_mask(int_mask), .brk_ack(brk_ack), .brk_req(brk_req),
        .brk_take(brk_take)
    );

    // Vector: addr, data, periph, isdata, write, expected flags {PB,CB,PA,CA}
    localparam int NV = 10;
    localparam logic [70:0] VEC [NV] = '{
        {32'h0000_1005, 32'h0,         1'b0, 1'b1, 1'b0, 4'b0001},
        {32'h0000_1005, 32'h0,         1'b1, 1'b1, 1'b0, 4'b0010},
        {32'h0000_1005, 32'h0,         1'b0, 1'b1, 1'b1, 4'b0000},
        {32'h0000_1005, 32'h0,         1'b0, 1'b0, 1'b0, 4'b0000},
        {32'h0000_1015, 32'h0,         1'b0, 1'b1, 1'b0, 4'b0000},
        {32'h0000_2000, 32'h0000_AB37, 1'b0, 1'b1, 1'b1, 4'b0100},
        {32'h0000_2000, 32'h0000_AC00, 1'b0, 1'b1, 1'b0, 4'b0000},
        {32'h0000_2000, 32'h0000_AB00, 1'b1, 1'b1, 1'b0, 4'b0000},
        {32'h0000_2000, 32'h0000_ABFF, 1'b0, 1'b0, 1'b0, 4'b0100},
        {32'h0000_2004, 32'h0000_AB00, 1'b0, 1'b1, 1'b0, 4'b0000}
    };

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [3:0] idx, input logic [31:0] val);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = idx; reg_wdata = val;
        @(negedge clk);
        reg_we = 1'b0; reg_addr = 4'd8;
    endtask

    // One bus cycle; returns at the falling edge after the capturing edge
    task automatic bus(input logic [70:0] v);
        @(negedge clk);
        bus_valid = 1'b1; bus_addr = v[70:39]; bus_data = v[38:7];
        bus_periph = v[6]; bus_isdata = v[5]; bus_write = v[4];
        @(negedge clk);
        bus_valid = 1'b0;
    endtask

    // Clear flags (keep post bit) and acknowledge
    task automatic clr(input logic post);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = 4'd8; reg_wdata = {27'd0, post, 4'd0};
        brk_ack = 1'b1;
        @(negedge clk);
        reg_we = 1'b0; brk_ack = 1'b0;
    endtask

    task automatic summary;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    initial begin
        #(8 * 100000);
        fails++;
        $display("FAIL watchdog actual=running expected=done");
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        for (int i = 0; i < 9; i++) begin
            reg_addr = 4'(i);
            #1 chk("R1 reg reset", reg_rdata, 32'h0);
        end
        reg_addr = 4'd8;
        chk("R1 req reset", {31'd0, brk_req}, 32'h0);

        // Program channels
        wr(4'd0, 32'h1000); wr(4'd1, 32'h000F); wr(4'd2, 32'h1B);
        wr(4'd3, 32'h2000); wr(4'd4, 32'h0);    wr(4'd5, 32'h3D);
        wr(4'd6, 32'hAB00); wr(4'd7, 32'h00FF);

        // Table walk: R2 R3 R4 R5 R8
        for (int k = 0; k < NV; k++) begin
            bus(VEC[k]);
            chk("R2/R3/R4/R5 flags", {28'd0, reg_rdata[3:0]}, {28'd0, VEC[k][3:0]});
            chk("R8 pre-exec request", {31'd0, brk_req}, {31'd0, |VEC[k][3:0]});
            clr(1'b0);
        end

        // R7 reserved bits and post bit readback; writing 1 to flags no effect
        wr(4'd8, 32'hFFFF_FFFF);
        chk("R7 ctrl readback", reg_rdata, 32'h10);
        wr(4'd8, 32'h0);

        // R4 zero group disables channel A and channel B
        wr(4'd2, 32'h18);
        bus(VEC[0]);
        chk("R4 src 00 disables", {27'd0, brk_req, reg_rdata[3:0]}, 32'h0);
        wr(4'd2, 32'h1B);
        wr(4'd5, 32'h31);
        bus(VEC[5]);
        chk("R4 acc 00 disables", {27'd0, brk_req, reg_rdata[3:0]}, 32'h0);
        wr(4'd5, 32'h3D);

        // R6 sticky flags, R9 pending held
        bus(VEC[0]);
        repeat (3) @(negedge clk);
        chk("R6 flag sticky", {28'd0, reg_rdata[3:0]}, 32'h1);
        chk("R9 req held", {31'd0, brk_req}, 32'h1);
        // R10 mask level
        int_mask = 4'hF; #1;
        chk("R10 mask 15 blocks", {30'd0, brk_req, brk_take}, 32'h2);
        int_mask = 4'hE; #1;
        chk("R10 mask 14 takes", {30'd0, brk_req, brk_take}, 32'h3);
        int_mask = 4'h0;
        wr(4'd8, 32'h0F);
        chk("R6 write 1 keeps", {28'd0, reg_rdata[3:0]}, 32'h1);
        // R9 ack clears request only
        @(negedge clk); brk_ack = 1'b1;
        @(negedge clk); brk_ack = 1'b0;
        chk("R9 ack clears req", {31'd0, brk_req}, 32'h0);
        chk("R9 ack keeps flag", {28'd0, reg_rdata[3:0]}, 32'h1);
        wr(4'd8, 32'h0);
        chk("R6 write 0 clears", {28'd0, reg_rdata[3:0]}, 32'h0);

        // R8 post-execution fetch break
        wr(4'd8, 32'h10);
        bus(VEC[8]);
        chk("R8 post flag set", {28'd0, reg_rdata[3:0]}, 32'h4);
        chk("R8 post no early req", {31'd0, brk_req}, 32'h0);
        repeat (2) @(negedge clk);
        chk("R8 post still waiting", {31'd0, brk_req}, 32'h0);
        insn_done = 1'b1;
        @(negedge clk); insn_done = 1'b0;
        chk("R8 post req after done", {31'd0, brk_req}, 32'h1);
        clr(1'b1);
        // R8 data access in post mode is immediate
        bus(VEC[5]);
        chk("R8 post data immediate", {31'd0, brk_req}, 32'h1);
        clr(1'b0);

        summary();
    end
endmodule